// File: doc/BRIEF.md
# TDM Multichannel Receive Channel Gate

This block sits behind the serial receive shifter of a time-division-multiplexed port. A frame holds up to 128 word slots, called channels and numbered from 0. A frame-sync pulse starts a frame at channel 0. Each word-complete strobe from the shifter closes the current channel and moves to the next one. For every finished word, the block decides whether the word moves on from the internal buffer register to the software-visible data register.

Channel enables come from a 128-bit bitmap made of eight 16-bit partition registers. Partition k covers channels 16k to 16k+15. With the select-mode input low, every channel in the frame is taken. With it high, only channels whose enable bit is set are taken. A word that is taken sets the ready flag and raises a one-cycle DMA request. When the interrupt mode is "interrupt on ready", it also raises a one-cycle interrupt. A word on a disabled channel stops in the buffer register.

Top module: `tdm_rx_gate`

## Requirements
- R1: After reset, `data_o`, `buf_o`, `ready_o`, `overrun_o`, `dma_req_o` and `irq_o` are all 0, and no frame is active.
- R2: `fsync_i` sets the current channel to 0 and opens a frame. Each `word_done_i` strobe inside an open frame advances the channel. After strobe number `frame_len_i` the frame closes, and later strobes are ignored until the next `fsync_i`. A `frame_len_i` of 0 or above 128 acts as 128. A strobe in the same cycle as `fsync_i`, or before the first `fsync_i`, is never taken.
- R3: With `sel_mode_i` = 0, every strobe inside an open frame is taken, whatever the enable bits hold.
- R4: With `sel_mode_i` = 1, the word on channel c is taken only if bit `16*(c/16) + c%16` of `chan_en_i` (bit c%16 of partition c/16) is 1.
- R5: The enable bits of partition k are captured when channel 16k begins (at `fsync_i` for k = 0). A write during block k therefore first acts on block k+1. A write to a partition whose block has already started acts from the next frame.
- R6: One cycle after a taken strobe, `data_o` holds the received word, `ready_o` is 1 and `dma_req_o` is high for exactly that cycle. A strobe that is not taken leaves `data_o` and `ready_o` unchanged and raises neither `dma_req_o` nor `irq_o`.
- R7: `buf_o` captures `rx_word_i` on every `word_done_i` strobe, taken or not, one cycle later.
- R8: `data_rd_i` clears `ready_o` on the next cycle. A read in the same cycle as a taken strobe leaves `ready_o` at 1, with the new word in `data_o`.
- R9: A taken strobe while `ready_o` is 1 and no read is present sets `overrun_o`, and `data_o` takes the new word. `overrun_o` stays set until a cycle with `data_rd_i` that does not itself set it again.
- R10: `irq_o` pulses for one cycle exactly when `ready_o` goes from 0 to 1 and `int_mode_i` was 2'b00 at the strobe. It stays 0 for any other mode.
- R11: With only channels 0, 15 and 39 enabled, select mode on and a frame length of 40, exactly three words per frame raise `dma_req_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fsync_i | input | 1 | Frame-sync pulse, starts a frame at channel 0 |
| word_done_i | input | 1 | Shifter has finished one word |
| rx_word_i | input | 16 | Word from the shifter |
| frame_len_i | input | 8 | Channels per frame (1..128; 0 or >128 means 128) |
| sel_mode_i | input | 1 | 0: all channels taken, 1: enable bitmap applies |
| int_mode_i | input | 2 | Interrupt mode; 2'b00 = interrupt on ready |
| chan_en_i | input | 128 | Eight 16-bit partition enable registers, partition k in bits 16k+15..16k |
| data_rd_i | input | 1 | Software read of the data register |
| data_o | output | 16 | Software-visible data register |
| buf_o | output | 16 | Receive buffer register |
| ready_o | output | 1 | Ready flag |
| overrun_o | output | 1 | Sticky overrun flag |
| dma_req_o | output | 1 | One-cycle DMA request per taken word |
| irq_o | output | 1 | One-cycle receive interrupt |

## Verification
The hardest case to reach from the ports is a write to the enable bits partway through a frame. The write must land inside one block and be seen to act only from the next block boundary, or only in the next frame when its partition has already begun. A directed frame changes the enables of the active partition and of the next partition after three words. The bench then counts the DMA pulses in that frame and in the frame after it. The random frames also rewrite whole partition registers at random points, with lengths that include 0 and values above 128, and the bench compares each of these against a cycle-level reference model.

// File: rtl/rxg_pkg.sv
// Package: shared constants and types for the TDM receive channel gate.
// Assumes: interrupt mode encoding where 2'b00 means "interrupt on ready".
package rxg_pkg;

    typedef enum logic [1:0] {
        IRQ_ON_READY = 2'b00,
        IRQ_MODE_1   = 2'b01,
        IRQ_MODE_2   = 2'b10,
        IRQ_MODE_3   = 2'b11
    } rx_irq_mode_e;

    localparam int DEF_NUM_CH  = 128;
    localparam int DEF_PART_CH = 16;
    localparam int DEF_WORD_W  = 16;

endpackage

// File: rtl/rxg_chan_track.sv
// Module: rxg_chan_track
// Tracks the channel position within a TDM frame. fsync_i opens a frame at
// channel 0. Each word strobe inside an open frame advances the channel, and
// the frame closes after the programmed number of words. The module also tells
// the enable bank when a new partition begins and which partition that is.
// Assumes: NUM_CH is a multiple of PART_CH, with at least two partitions.
module rxg_chan_track #(
    parameter int NUM_CH  = 128,
    parameter int PART_CH = 16,
    localparam int CH_W   = $clog2(NUM_CH),
    localparam int PW     = $clog2(PART_CH),
    localparam int BLK_W  = CH_W - PW,
    localparam int LEN_W  = CH_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fsync_i,
    input  logic             word_done_i,
    input  logic [LEN_W-1:0] frame_len_i,
    output logic [PW-1:0]    chan_lo_o,
    output logic             active_o,
    output logic             step_o,
    output logic             blk_load_o,
    output logic [BLK_W-1:0] blk_idx_o
);

    logic [CH_W-1:0]  chan_q;
    logic             active_q;
    logic [LEN_W-1:0] len_eff;
    logic [LEN_W-1:0] last_w;
    logic [CH_W-1:0]  last_ch;
    logic             at_last;
    logic             blk_end;

    // Clamp the frame length: 0 or anything above NUM_CH means a full frame.
    always_comb begin
        if (frame_len_i == '0 || frame_len_i > LEN_W'(NUM_CH)) begin
            len_eff = LEN_W'(NUM_CH);
        end else begin
            len_eff = frame_len_i;
        end
        last_w  = len_eff - LEN_W'(1);
        last_ch = last_w[CH_W-1:0];
    end

    // A strobe counts only inside an open frame and never together with sync.
    assign step_o  = word_done_i && !fsync_i && active_q;
    assign at_last = (chan_q == last_ch);
    assign blk_end = &chan_q[PW-1:0];

    // Partition boundary: frame start, or a step from the final slot of a block.
    assign blk_load_o = fsync_i || (step_o && blk_end && !at_last);
    assign blk_idx_o  = fsync_i ? '0 : (chan_q[CH_W-1:PW] + BLK_W'(1));

    // Channel counter and frame-open flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chan_q   <= '0;
            active_q <= 1'b0;
        end else if (fsync_i) begin
            chan_q   <= '0;
            active_q <= 1'b1;
        end else if (step_o) begin
            if (at_last) begin
                active_q <= 1'b0;
            end else begin
                chan_q <= chan_q + CH_W'(1);
            end
        end
    end

    assign chan_lo_o = chan_q[PW-1:0];
    assign active_o  = active_q;

endmodule

// File: rtl/rxg_en_shadow.sv
// Module: rxg_en_shadow
// Holds a snapshot of the enable register for the partition now in progress.
// The flat enable bitmap is split into per-partition words. The snapshot of a
// partition is taken when its block begins, so a write during a block first
// acts on the next one.
// Assumes: blk_load_i and blk_idx_i come from rxg_chan_track.
module rxg_en_shadow #(
    parameter int NUM_CH   = 128,
    parameter int PART_CH  = 16,
    localparam int NUM_PART = NUM_CH / PART_CH,
    localparam int PW       = $clog2(PART_CH),
    localparam int BLK_W    = $clog2(NUM_PART)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] chan_en_i,
    input  logic              blk_load_i,
    input  logic [BLK_W-1:0]  blk_idx_i,
    input  logic [PW-1:0]     chan_lo_i,
    output logic              slot_en_o
);

    logic [PART_CH-1:0] part_en [NUM_PART];
    logic [PART_CH-1:0] shadow_q;

    // Unpack the flat bitmap into one word per partition.
    for (genvar g = 0; g < NUM_PART; g++) begin : g_part
        assign part_en[g] = chan_en_i[g*PART_CH +: PART_CH];
    end

    // Capture the enables of the partition that is starting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= '0;
        end else if (blk_load_i) begin
            shadow_q <= part_en[blk_idx_i];
        end
    end

    assign slot_en_o = shadow_q[chan_lo_i];

endmodule

// File: rtl/rxg_deliver.sv
// Module: rxg_deliver
// Moves taken words from the strobe into the data register. It keeps the
// receive buffer register, the ready and overrun flags, and the one-cycle DMA
// request and interrupt pulses.
// Assumes: step_i is a qualified in-frame strobe and slot_en_i is the enable
// bit of the current channel.
module rxg_deliver
    import rxg_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_done_i,
    input  logic              step_i,
    input  logic              slot_en_i,
    input  logic              sel_mode_i,
    input  logic [1:0]        int_mode_i,
    input  logic [WORD_W-1:0] rx_word_i,
    input  logic              data_rd_i,
    output logic [WORD_W-1:0] data_o,
    output logic [WORD_W-1:0] buf_o,
    output logic              ready_o,
    output logic              overrun_o,
    output logic              dma_req_o,
    output logic              irq_o
);

    logic accept;
    logic irq_on_ready;

    assign accept       = step_i && (!sel_mode_i || slot_en_i);
    assign irq_on_ready = (int_mode_i == IRQ_ON_READY);

    // Buffer register: loads on every finished word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_o <= '0;
        end else if (word_done_i) begin
            buf_o <= rx_word_i;
        end
    end

    // Data register and ready flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_o  <= '0;
            ready_o <= 1'b0;
        end else if (accept) begin
            data_o  <= rx_word_i;
            ready_o <= 1'b1;
        end else if (data_rd_i) begin
            ready_o <= 1'b0;
        end
    end

    // Sticky overrun: set by a new word over an unread one, cleared by a read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            overrun_o <= 1'b0;
        end else if (accept && ready_o && !data_rd_i) begin
            overrun_o <= 1'b1;
        end else if (data_rd_i) begin
            overrun_o <= 1'b0;
        end
    end

    // One-cycle event pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dma_req_o <= 1'b0;
            irq_o     <= 1'b0;
        end else begin
            dma_req_o <= accept;
            irq_o     <= accept && !ready_o && irq_on_ready;
        end
    end

endmodule

// File: rtl/tdm_rx_gate.sv
// Module: tdm_rx_gate (top)
// Receive channel gating for a TDM frame of up to NUM_CH word channels, with
// per-channel enables grouped in partitions of PART_CH channels.
// Assumes: word strobes come from a receive shifter in the same clock domain.
module tdm_rx_gate #(
    parameter int NUM_CH   = 128,
    parameter int PART_CH  = 16,
    parameter int WORD_W   = 16,
    localparam int CH_W    = $clog2(NUM_CH),
    localparam int PW      = $clog2(PART_CH),
    localparam int BLK_W   = CH_W - PW,
    localparam int LEN_W   = CH_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fsync_i,
    input  logic              word_done_i,
    input  logic [WORD_W-1:0] rx_word_i,
    input  logic [LEN_W-1:0]  frame_len_i,
    input  logic              sel_mode_i,
    input  logic [1:0]        int_mode_i,
    input  logic [NUM_CH-1:0] chan_en_i,
    input  logic              data_rd_i,
    output logic [WORD_W-1:0] data_o,
    output logic [WORD_W-1:0] buf_o,
    output logic              ready_o,
    output logic              overrun_o,
    output logic              dma_req_o,
    output logic              irq_o
);

    logic [PW-1:0]    chan_lo;
    logic             frame_act;
    logic             step;
    logic             blk_load;
    logic [BLK_W-1:0] blk_idx;
    logic             slot_en;

    rxg_chan_track #(
        .NUM_CH  (NUM_CH),
        .PART_CH (PART_CH)
    ) u_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .fsync_i     (fsync_i),
        .word_done_i (word_done_i),
        .frame_len_i (frame_len_i),
        .chan_lo_o   (chan_lo),
        .active_o    (frame_act),
        .step_o      (step),
        .blk_load_o  (blk_load),
        .blk_idx_o   (blk_idx)
    );

    rxg_en_shadow #(
        .NUM_CH  (NUM_CH),
        .PART_CH (PART_CH)
    ) u_shadow (
        .clk        (clk),
        .rst_n      (rst_n),
        .chan_en_i  (chan_en_i),
        .blk_load_i (blk_load),
        .blk_idx_i  (blk_idx),
        .chan_lo_i  (chan_lo),
        .slot_en_o  (slot_en)
    );

    rxg_deliver #(
        .WORD_W (WORD_W)
    ) u_deliver (
        .clk         (clk),
        .rst_n       (rst_n),
        .word_done_i (word_done_i),
        .step_i      (step),
        .slot_en_i   (slot_en),
        .sel_mode_i  (sel_mode_i),
        .int_mode_i  (int_mode_i),
        .rx_word_i   (rx_word_i),
        .data_rd_i   (data_rd_i),
        .data_o      (data_o),
        .buf_o       (buf_o),
        .ready_o     (ready_o),
        .overrun_o   (overrun_o),
        .dma_req_o   (dma_req_o),
        .irq_o       (irq_o)
    );

endmodule

// File: rtl/tdm_rx_gate_chk.sv
// Module: tdm_rx_gate_chk
// Checker holding the temporal properties of tdm_rx_gate, bound to the top.
// Assumes: synchronous active-low reset held low from time zero.
module tdm_rx_gate_chk #(
    parameter int WORD_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fsync_i,
    input logic              word_done_i,
    input logic [WORD_W-1:0] rx_word_i,
    input logic              sel_mode_i,
    input logic [1:0]        int_mode_i,
    input logic              frame_act,
    input logic [WORD_W-1:0] data_o,
    input logic [WORD_W-1:0] buf_o,
    input logic              ready_o,
    input logic              overrun_o,
    input logic              dma_req_o,
    input logic              irq_o
);

    // R10: an interrupt only accompanies a rising ready flag.
    a_r10_irq_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (ready_o && !$past(ready_o)));

    // R10: an interrupt only in the interrupt-on-ready mode.
    a_r10_irq_mode: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ($past(int_mode_i) == 2'b00));

    // R6: a DMA request carries the word strobed in the cycle before.
    a_r6_dma_data: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req_o |-> ($past(word_done_i) && ready_o && data_o == $past(rx_word_i)));

    // R6: ready only rises together with a DMA request.
    a_r6_ready_src: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_o) |-> dma_req_o);

    // R9: overrun only sets on a taken word.
    a_r9_ovr_src: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun_o) |-> dma_req_o);

    // R7: the buffer follows every strobe.
    a_r7_buf_load: assert property (@(posedge clk) disable iff (!rst_n)
        $past(word_done_i) |-> (buf_o == $past(rx_word_i)));

    // R2: nothing is taken while no frame is open.
    a_r2_closed_frame: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(frame_act) |-> !dma_req_o);

    // R3: in all-channel mode every in-frame strobe is taken.
    a_r3_all_taken: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(word_done_i) && !$past(fsync_i) && !$past(sel_mode_i) && $past(frame_act))
        |-> dma_req_o);

endmodule

bind tdm_rx_gate tdm_rx_gate_chk #(.WORD_W(WORD_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fsync_i     (fsync_i),
    .word_done_i (word_done_i),
    .rx_word_i   (rx_word_i),
    .sel_mode_i  (sel_mode_i),
    .int_mode_i  (int_mode_i),
    .frame_act   (frame_act),
    .data_o      (data_o),
    .buf_o       (buf_o),
    .ready_o     (ready_o),
    .overrun_o   (overrun_o),
    .dma_req_o   (dma_req_o),
    .irq_o       (irq_o)
);

// File: tb/tdm_rx_gate_tb_top.sv
`timescale 1ns/1ps
module tdm_rx_gate_tb_top;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         fsync_i = 1'b0;
    logic         word_done_i = 1'b0;
    logic [15:0]  rx_word_i = '0;
    logic [7:0]   frame_len_i = 8'd0;
    logic         sel_mode_i = 1'b0;
    logic [1:0]   int_mode_i = 2'b00;
    logic [127:0] chan_en_i;
    logic         data_rd_i = 1'b0;
    logic [15:0]  data_o, buf_o;
    logic         ready_o, overrun_o, dma_req_o, irq_o;

    logic [15:0]  en_reg [8];

    int checks = 0;
    int errors = 0;
    int dma_cnt = 0;
    bit done = 1'b0;

    // Reference model state
    logic [6:0]  m_chan;
    logic        m_act;
    logic [15:0] m_shadow;
    logic [15:0] m_data, m_buf;
    logic        m_ready, m_ovr, m_dma, m_irq;

    always #4 clk = ~clk;

    always_comb begin
        for (int k = 0; k < 8; k++) chan_en_i[k*16 +: 16] = en_reg[k];
    end

    tdm_rx_gate dut_i (
        .clk(clk), .rst_n(rst_n), .fsync_i(fsync_i), .word_done_i(word_done_i),
        .rx_word_i(rx_word_i), .frame_len_i(frame_len_i), .sel_mode_i(sel_mode_i),
        .int_mode_i(int_mode_i), .chan_en_i(chan_en_i), .data_rd_i(data_rd_i),
        .data_o(data_o), .buf_o(buf_o), .ready_o(ready_o), .overrun_o(overrun_o),
        .dma_req_o(dma_req_o), .irq_o(irq_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int last_chan();
        if (frame_len_i == 0 || frame_len_i > 8'd128) return 127;
        return int'(frame_len_i) - 1;
    endfunction

    task automatic model_reset();
        m_chan = '0; m_act = 1'b0; m_shadow = '0; m_data = '0; m_buf = '0;
        m_ready = 1'b0; m_ovr = 1'b0; m_dma = 1'b0; m_irq = 1'b0;
    endtask

    // Drive one cycle (called at a falling edge), update the model, compare.
    task automatic step(input logic fs, input logic wd, input logic [15:0] w, input logic rd);
        logic acc;
        fsync_i = fs; word_done_i = wd; rx_word_i = w; data_rd_i = rd;
        acc = wd && !fs && m_act && (!sel_mode_i || m_shadow[m_chan[3:0]]);
        if (wd) m_buf = w;
        m_dma = acc;
        m_irq = acc && !m_ready && (int_mode_i == 2'b00);
        if (acc && m_ready && !rd) m_ovr = 1'b1; else if (rd) m_ovr = 1'b0;
        if (acc) begin m_data = w; m_ready = 1'b1; end else if (rd) m_ready = 1'b0;
        if (fs) begin
            m_chan = '0; m_act = 1'b1; m_shadow = en_reg[0];
        end else if (wd && m_act) begin
            if (int'(m_chan) == last_chan()) m_act = 1'b0;
            else begin
                if (m_chan[3:0] == 4'hf) m_shadow = en_reg[m_chan[6:4] + 3'd1];
                m_chan = m_chan + 7'd1;
            end
        end
        @(negedge clk);
        fsync_i = 1'b0; word_done_i = 1'b0; data_rd_i = 1'b0;
        if (dma_req_o) dma_cnt++;
        chk("R6 data_o", int'(data_o), int'(m_data));
        chk("R7 buf_o", int'(buf_o), int'(m_buf));
        chk("R8 ready_o", int'(ready_o), int'(m_ready));
        chk("R9 overrun_o", int'(overrun_o), int'(m_ovr));
        chk("R6 dma_req_o", int'(dma_req_o), int'(m_dma));
        chk("R10 irq_o", int'(irq_o), int'(m_irq));
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int k = 0; k < 8; k++) en_reg[k] = '0;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1 data_o", int'(data_o), 0);
        chk("R1 ready_o", int'(ready_o), 0);
        chk("R1 dma_req_o", int'(dma_req_o), 0);
        chk("R1 overrun_o", int'(overrun_o), 0);

        // R2: strobes before any frame sync are not taken
        dma_cnt = 0;
        for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 16'h1000 + 16'(i), 1'b0);
        chk("R2 pre-sync strobes", dma_cnt, 0);

        // R3: all-channel mode ignores enables; length 5, extra strobes dropped
        sel_mode_i = 1'b0; frame_len_i = 8'd5; dma_cnt = 0;
        step(1'b1, 1'b1, 16'hdead, 1'b0);      // strobe with sync: dropped (R2)
        for (int i = 0; i < 8; i++) step(1'b0, 1'b1, 16'h2000 + 16'(i), 1'b1);
        chk("R3 all channels taken", dma_cnt, 5);
        chk("R2 strobes past frame end", int'(data_o), 16'h2004);

        // R9/R8: overrun, then read alongside a new word
        frame_len_i = 8'd4; dma_cnt = 0;
        step(1'b1, 1'b0, 16'h0, 1'b0);
        step(1'b0, 1'b1, 16'h3000, 1'b0);
        step(1'b0, 1'b1, 16'h3001, 1'b0);
        chk("R9 overrun set", int'(overrun_o), 1);
        step(1'b0, 1'b1, 16'h3002, 1'b1);
        chk("R8 read with new word keeps ready", int'(ready_o), 1);
        step(1'b0, 1'b0, 16'h0, 1'b1);
        chk("R8 ready cleared by read", int'(ready_o), 0);

        // R10: no interrupt in another mode
        int_mode_i = 2'b01;
        step(1'b1, 1'b0, 16'h0, 1'b0);
        step(1'b0, 1'b1, 16'h3100, 1'b0);
        chk("R10 no irq in mode 01", int'(irq_o), 0);
        step(1'b0, 1'b0, 16'h0, 1'b1);
        int_mode_i = 2'b00;

        // R11/R4: channels 0, 15 and 39 only, frame length 40
        sel_mode_i = 1'b1; frame_len_i = 8'd40;
        for (int k = 0; k < 8; k++) en_reg[k] = '0;
        en_reg[0] = 16'h8001; en_reg[2] = 16'h0080;
        for (int f = 0; f < 2; f++) begin
            dma_cnt = 0;
            step(1'b1, 1'b0, 16'h0, 1'b0);
            for (int c = 0; c < 40; c++) step(1'b0, 1'b1, 16'h4000 + 16'(c), 1'b1);
            chk("R11 three words per frame", dma_cnt, 3);
            chk("R4 last taken is channel 39", int'(data_o), 16'h4027);
        end

        // R5: writes during block 0 act on block 1 now, on block 0 next frame
        frame_len_i = 8'd32;
        en_reg[0] = 16'hffff; en_reg[1] = 16'h0000; dma_cnt = 0;
        step(1'b1, 1'b0, 16'h0, 1'b0);
        for (int c = 0; c < 3; c++) step(1'b0, 1'b1, 16'h5000 + 16'(c), 1'b1);
        en_reg[0] = 16'h0000; en_reg[1] = 16'hffff;
        for (int c = 3; c < 32; c++) step(1'b0, 1'b1, 16'h5000 + 16'(c), 1'b1);
        chk("R5 mid-block write deferred", dma_cnt, 32);
        dma_cnt = 0;
        step(1'b1, 1'b0, 16'h0, 1'b0);
        for (int c = 0; c < 32; c++) step(1'b0, 1'b1, 16'h5100 + 16'(c), 1'b1);
        chk("R5 write applied next frame", dma_cnt, 16);

        // Random frames checked cycle by cycle against the model
        for (int f = 0; f < 10; f++) begin
            sel_mode_i  = 1'($urandom_range(0, 3) != 0);
            int_mode_i  = ($urandom_range(0, 3) == 0) ? 2'($urandom_range(1, 3)) : 2'b00;
            frame_len_i = 8'($urandom_range(0, 140));
            for (int k = 0; k < 8; k++) en_reg[k] = 16'($urandom);
            step(1'b1, 1'b0, 16'h0, 1'b0);
            for (int i = 0; i < 150; i++) begin
                if ($urandom_range(0, 19) == 0)
                    en_reg[$urandom_range(0, 7)] = 16'($urandom);
                step(1'b0, 1'($urandom_range(0, 3) != 0), 16'($urandom),
                     1'($urandom_range(0, 1)));
            end
        end

        summary();
    end

endmodule